// File: doc/BRIEF.md
# Multiplexed Pseudo-SRAM Host Controller

This block sits on the host side of an external 16-bit memory whose address and data share one set of pins. A user-side request is a single word or single byte read or write: a request-valid strobe, a write flag, a 19-bit word address, 16 bits of write data and two byte enables. The controller accepts the request when it shows ready. It then runs the pin sequence on the memory bus and, for a read, returns the data with a one-clock valid pulse.

Every transaction has two phases. In the address phase, chip select and address valid go low together. The low 16 address bits go out on the shared bus and the top three bits go out on dedicated pins. In the data phase, a read first releases the host drivers, then drops output enable and samples the bus. A write keeps the bus driven with the data and holds write enable low. Every phase length is a whole number of clock cycles. Each is computed at elaboration from the clock period and the nanosecond limits, rounded up. After reset the controller keeps chip select high for a power-up hold before it accepts any request.

Top module: `mpsram_ctrl`

## Requirements
- R1: After reset release, `ready` stays low and `mem_cs_n` stays high for `ceil(POWERUP_NS/CLK_NS)` clock cycles, and any request offered during that time starts no transaction.
- R2: Accepting a request (`req_valid` high while `ready` is high) starts an address phase. In it, `mem_cs_n` and `mem_avd_n` are low together, `adq_oe` is 1, `adq_out` carries address bits 15:0, `mem_ahi` carries address bits 18:16, and both byte strobes are high. The phase lasts the largest of `ceil(15 ns)`, `ceil(15 ns)` and `ceil(7 ns)` in cycles.
- R3: After `mem_avd_n` rises, the address stays driven on `adq_out` with chip select low for `max(1, ceil(5 ns))` cycles.
- R4: The host never drives the bus while `mem_oe_n` is low. The host drivers are off in the cycle just before `mem_oe_n` falls.
- R5: For a read, `mem_oe_n` stays low for `max(ceil(25 ns), ceil(70 ns) - address cycles - hold cycles - 1)` cycles. The bus is sampled on the last of those cycles. `rd_data` is then presented with `rd_valid` high for exactly one cycle, and bytes whose enable is 0 read as zero.
- R6: For a write, `mem_we_n` stays low for `max(ceil(45 ns), ceil(70 ns) - address cycles - hold cycles)` cycles, with `adq_out` holding the write data and `adq_oe` high throughout. The data stays driven for one more cycle after `mem_we_n` rises.
- R7: During the data phase, `mem_lb_n` is low exactly when byte enable bit 0 is set, which selects bus bits 7:0. `mem_ub_n` is low exactly when bit 1 is set, which selects bits 15:8. Both enables set give a word access.
- R8: `ready` is low from acceptance until chip select has returned high (for a read, until the recovery time has also ended). A request offered while `ready` is low is ignored.
- R9: After `mem_oe_n` rises, the host drivers stay off for at least `ceil(15 ns)` cycles.
- R10: All cycle counts derive from `CLK_NS` and the nanosecond parameters by rounding up. At 5 ns this gives 3 address cycles, 1 hold cycle, 9 output-enable cycles, 10 write-enable cycles and 3 recovery cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when ready is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte, bit 1 = high byte |
| ready | output | 1 | Controller idle and able to accept a request |
| rd_valid | output | 1 | One-cycle pulse marking valid rd_data |
| rd_data | output | 16 | Read data, disabled bytes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_avd_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ahi | output | 3 | Address bits 18:16 |
| adq_out | output | 16 | Value the host drives on the shared bus |
| adq_oe | output | 1 | Host bus driver enable |
| adq_in | input | 16 | Value read from the shared bus |

## Verification
A pin-level memory model in the bench records each latched address from the bus pins and commits writes when write enable rises. Read results are checked against a separate reference map built only from the requests issued. A mismatch therefore separates a wrong address or wrong byte merge from a timing fault. Random traffic mixes reads and writes over a small address pool that includes both ends of the address range, with all three non-zero byte-enable patterns. This exercises both byte lanes and read-after-write merging. Directed cases cover a byte write into a word that is already set, requests offered during power-up and while busy, and back-to-back reads. The back-to-back reads test the recovery gap before the next address is driven.

// File: rtl/mpsram_ctrl.sv
module mpsram_ctrl #(
  parameter int CLK_NS      = 5,
  parameter int POWERUP_NS  = 200000,
  parameter int T_AVDL_NS   = 15,
  parameter int T_ASET_NS   = 15,
  parameter int T_AHOLD_NS  = 5,
  parameter int T_CSS_NS    = 7,
  parameter int T_ACC_NS    = 70,
  parameter int T_OE_NS     = 25,
  parameter int T_WRL_NS    = 45,
  parameter int T_ACW_NS    = 70,
  parameter int T_OHZ_NS    = 15,
  parameter int AW          = 19,
  parameter int DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_cs_n,
  output logic          mem_avd_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [AW-17:0] mem_ahi,
  output logic [DW-1:0] adq_out,
  output logic          adq_oe,
  input  logic [DW-1:0] adq_in
);

  function automatic int cyc(int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int AVD_CYC  = imax(imax(cyc(T_AVDL_NS), cyc(T_ASET_NS)), imax(cyc(T_CSS_NS), 1));
  localparam int HOLD_CYC = imax(1, cyc(T_AHOLD_NS));
  localparam int RD_CYC   = imax(imax(cyc(T_OE_NS), cyc(T_ACC_NS) - AVD_CYC - HOLD_CYC - 1), 1);
  localparam int WE_CYC   = imax(imax(cyc(T_WRL_NS), cyc(T_ACW_NS) - AVD_CYC - HOLD_CYC), 1);
  localparam int OHZ_CYC  = imax(1, cyc(T_OHZ_NS));
  localparam int PWR_CYC  = imax(1, cyc(POWERUP_NS));
  localparam int PH_MAX   = imax(imax(AVD_CYC, HOLD_CYC), imax(imax(RD_CYC, WE_CYC), OHZ_CYC));
  localparam int PCW      = $clog2(PH_MAX + 1);
  localparam int PWW      = $clog2(PWR_CYC + 1);

  typedef enum logic [3:0] {
    S_PWR, S_IDLE, S_ADDR, S_HOLD, S_TURN, S_RDW, S_WR, S_WEND, S_REC
  } st_t;

  st_t             st;
  logic [PCW-1:0]  cnt;
  logic [PWW-1:0]  pcnt;
  logic [AW-1:0]   a_q;
  logic [DW-1:0]   d_q;
  logic [1:0]      be_q;
  logic            we_q;
  logic            dphase;
  logic [DW-1:0]   bmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PWR;
      cnt      <= '0;
      pcnt     <= '0;
      a_q      <= '0;
      d_q      <= '0;
      be_q     <= '0;
      we_q     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_PWR: begin
          if (pcnt == PWW'(PWR_CYC - 1)) st <= S_IDLE;
          else pcnt <= pcnt + 1'b1;
        end
        S_IDLE: begin
          if (req_valid) begin
            a_q  <= req_addr;
            d_q  <= req_wdata;
            be_q <= req_be;
            we_q <= req_we;
            cnt  <= PCW'(AVD_CYC - 1);
            st   <= S_ADDR;
          end
        end
        S_ADDR: begin
          if (cnt == '0) begin
            cnt <= PCW'(HOLD_CYC - 1);
            st  <= S_HOLD;
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (cnt == '0) begin
            if (we_q) begin
              cnt <= PCW'(WE_CYC - 1);
              st  <= S_WR;
            end else st <= S_TURN;
          end else cnt <= cnt - 1'b1;
        end
        S_TURN: begin
          cnt <= PCW'(RD_CYC - 1);
          st  <= S_RDW;
        end
        S_RDW: begin
          if (cnt == '0) begin
            rd_data  <= adq_in & bmask;
            rd_valid <= 1'b1;
            cnt      <= PCW'(OHZ_CYC - 1);
            st       <= S_REC;
          end else cnt <= cnt - 1'b1;
        end
        S_WR: begin
          if (cnt == '0) st <= S_WEND;
          else cnt <= cnt - 1'b1;
        end
        S_WEND: st <= S_IDLE;
        S_REC: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bmask     = {{(DW/2){be_q[1]}}, {(DW/2){be_q[0]}}};
  assign dphase    = (st == S_RDW) || (st == S_WR);
  assign ready     = (st == S_IDLE);
  assign mem_cs_n  = !(st inside {S_ADDR, S_HOLD, S_TURN, S_RDW, S_WR, S_WEND});
  assign mem_avd_n = (st != S_ADDR);
  assign mem_oe_n  = (st != S_RDW);
  assign mem_we_n  = (st != S_WR);
  assign mem_lb_n  = !(dphase && be_q[0]);
  assign mem_ub_n  = !(dphase && be_q[1]);
  assign mem_ahi   = a_q[AW-1:16];
  assign adq_oe    = st inside {S_ADDR, S_HOLD, S_WR, S_WEND};
  assign adq_out   = (st == S_WR || st == S_WEND) ? d_q : a_q[DW-1:0];

endmodule

module mpsram_ctrl_chk #(
  parameter int PWR_CYC = 1,
  parameter int AVD_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic rd_valid,
  input logic cs_n,
  input logic avd_n,
  input logic oe_n,
  input logic we_n,
  input logic ub_n,
  input logic lb_n,
  input logic drv
);
  localparam int PW = $clog2(PWR_CYC + 1);
  localparam int AWD = $clog2(AVD_CYC + 2);

  logic [PW-1:0]  since;
  logic [AWD-1:0] avd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since   <= '0;
      avd_run <= '0;
    end else begin
      if (since != PW'(PWR_CYC)) since <= since + 1'b1;
      if (avd_n) avd_run <= '0;
      else if (avd_run != AWD'(AVD_CYC + 1)) avd_run <= avd_run + 1'b1;
    end
  end

  AST_PWRUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (since < PW'(PWR_CYC)) |-> (cs_n && !ready)); // R1
  AST_AVD_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avd_n) |-> (avd_run >= AWD'(AVD_CYC))); // R2
  AST_AVD_PHASE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !avd_n |-> (!cs_n && ub_n && lb_n && drv)); // R2
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !drv); // R4
  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(drv)); // R4
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)); // R6
  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ready); // R8
  AST_RECOVERY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> !drv); // R9
endmodule

bind mpsram_ctrl mpsram_ctrl_chk #(.PWR_CYC(PWR_CYC), .AVD_CYC(AVD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rd_valid(rd_valid),
  .cs_n(mem_cs_n), .avd_n(mem_avd_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
  .ub_n(mem_ub_n), .lb_n(mem_lb_n), .drv(adq_oe)
);

// File: tb/tb_mpsram_ctrl.sv
`timescale 1ns/1ps
module tb_mpsram_ctrl;
  localparam int CLKNS = 5;
  localparam int PWRNS = 2000;

  function automatic int cd(int ns); return (ns + CLKNS - 1) / CLKNS; endfunction
  function automatic int mx(int a, int b); return a > b ? a : b; endfunction
  localparam int E_AVD = mx(cd(15), cd(7));
  localparam int E_RD  = mx(cd(25), cd(70) - E_AVD - 1 - 1);
  localparam int E_WE  = mx(cd(45), cd(70) - E_AVD - 1);
  localparam int E_OHZ = cd(15);
  localparam int E_PWR = cd(PWRNS);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic ready, rd_valid, mem_cs_n, mem_avd_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, adq_oe;
  logic [15:0] rd_data, adq_out;
  logic [15:0] adq_in = 16'hDEAD;
  logic [2:0]  mem_ahi;

  mpsram_ctrl #(.CLK_NS(CLKNS), .POWERUP_NS(PWRNS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_cs_n(mem_cs_n), .mem_avd_n(mem_avd_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_ahi(mem_ahi), .adq_out(adq_out), .adq_oe(adq_oe), .adq_in(adq_in));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] pmem [logic [18:0]];
  logic [15:0] rmem [logic [18:0]];

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_p(logic [18:0] a);
    return pmem.exists(a) ? pmem[a] : 16'h0;
  endfunction
  function automatic logic [15:0] rd_r(logic [18:0] a);
    return rmem.exists(a) ? rmem[a] : 16'h0;
  endfunction
  function automatic logic [15:0] merge(logic [15:0] o, logic [15:0] n, logic [1:0] be);
    return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
  endfunction

  // pin-level monitor and memory model
  int avd_run = 0, oe_run = 0, we_run = 0, last_avd = 0, last_oe = 0, last_we = 0;
  int n_txn = 0, rec_cnt = 0;
  bit rec_armed = 0;
  int v_ready = 0, v_addr = 0, v_hold = 0, v_turn = 0, v_rec = 0, v_wdata = 0, v_strb = 0;
  logic p_avd = 1, p_oe = 1, p_we = 1, p_drv = 0;
  logic [18:0] lat_addr = '0;
  logic [15:0] pend_d = '0, cur_wd = '0;
  logic [1:0]  pend_be = '0, cur_be = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_cs_n && ready) v_ready++;
      if (!mem_avd_n) begin
        avd_run++;
        lat_addr = {mem_ahi, adq_out};
        if (!adq_oe || mem_cs_n || !mem_ub_n || !mem_lb_n) v_addr++;
      end
      if (!p_avd && mem_avd_n) begin
        last_avd = avd_run; avd_run = 0; n_txn++;
        if (!adq_oe || mem_cs_n || adq_out != lat_addr[15:0]) v_hold++;
      end
      if (!mem_oe_n) begin
        oe_run++;
        if (adq_oe) v_turn++;
        if ({mem_ub_n, mem_lb_n} != ~cur_be) v_strb++;
      end
      if (p_oe && !mem_oe_n && p_drv) v_turn++;
      if (!p_oe && mem_oe_n) begin
        last_oe = oe_run; oe_run = 0; rec_armed = 1; rec_cnt = 0;
      end
      if (rec_armed) begin
        if (adq_oe) begin
          if (rec_cnt < E_OHZ) v_rec++;
          rec_armed = 0;
        end else rec_cnt++;
      end
      if (!mem_we_n) begin
        we_run++;
        pend_d = adq_out; pend_be = ~{mem_ub_n, mem_lb_n};
        if (!adq_oe || adq_out != cur_wd) v_wdata++;
        if ({mem_ub_n, mem_lb_n} != ~cur_be) v_strb++;
      end
      if (!p_we && mem_we_n) begin
        last_we = we_run; we_run = 0;
        if (!adq_oe || adq_out != pend_d) v_hold++;
        pmem[lat_addr] = merge(rd_p(lat_addr), pend_d, pend_be);
      end
      adq_in <= (!mem_cs_n && !mem_oe_n) ? rd_p(lat_addr) : 16'hDEAD;
      p_avd = mem_avd_n; p_oe = mem_oe_n; p_we = mem_we_n; p_drv = adq_oe;
    end
  end

  task automatic do_op(bit w, logic [18:0] a, logic [15:0] d, logic [1:0] be, bit poke);
    int n0;
    logic [15:0] exp;
    while (!ready) @(negedge clk);
    n0 = n_txn;
    cur_be = be; cur_wd = d;
    req_valid = 1; req_we = w; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    if (poke) begin
      req_addr = a ^ 19'h00155; req_wdata = ~d;
      repeat (5) @(negedge clk);
    end
    req_valid = 0;
    if (w) begin
      while (!ready) @(negedge clk);
      rmem[a] = merge(rd_r(a), d, be);
      chk(last_we == E_WE, "R6/R10 write-enable width", last_we, E_WE);
    end else begin
      for (int i = 0; i < 100 && !rd_valid; i++) @(negedge clk);
      exp = rd_r(a) & {{8{be[1]}}, {8{be[0]}}};
      chk(rd_valid, "R5 read valid seen", rd_valid, 1);
      chk(rd_data == exp, "R5 R7 read data", rd_data, exp);
      @(negedge clk);
      chk(!rd_valid, "R5 valid one cycle", rd_valid, 0);
      chk(last_oe == E_RD, "R5/R10 output-enable width", last_oe, E_RD);
    end
    chk(n_txn == n0 + 1, "R8 one transaction per request", n_txn - n0, 1);
    chk(lat_addr == a, "R2 latched address", lat_addr, a);
    chk(last_avd == E_AVD, "R2/R10 address-valid width", last_avd, E_AVD);
  endtask

  initial begin
    logic [18:0] pool [8];
    int n;
    void'($urandom(32'h5EED_0042));
    pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h10000; pool[3] = 19'h0FFFF;
    for (int i = 4; i < 8; i++) pool[i] = 19'($urandom);
    repeat (3) @(negedge clk);
    chk(ready == 0 && mem_cs_n == 1 && adq_oe == 0, "R1 reset state", {ready, mem_cs_n, adq_oe}, 3'b010);
    rst_n = 1;
    n = 0;
    while (!ready && n < E_PWR + 10) begin
      if (!mem_cs_n) v_ready++;
      req_valid = (n >= 10 && n < 20);
      req_we = 1; req_addr = 19'h00321; req_wdata = 16'hBAD0; req_be = 2'b11;
      n++;
      @(negedge clk);
    end
    req_valid = 0;
    chk(n == E_PWR, "R1 power-up hold length", n, E_PWR);
    chk(n_txn == 0, "R1 requests ignored during power-up", n_txn, 0);

    do_op(1, 19'h7FFFF, 16'h1234, 2'b11, 0);
    do_op(0, 19'h7FFFF, 16'h0, 2'b11, 0);
    do_op(1, 19'h7FFFF, 16'hAB00, 2'b10, 0);
    do_op(0, 19'h7FFFF, 16'h0, 2'b11, 0);
    do_op(1, 19'h00000, 16'h00CD, 2'b01, 1);
    do_op(0, 19'h00000 ^ 19'h00155, 16'h0, 2'b11, 0);
    do_op(0, 19'h00000, 16'h0, 2'b01, 0);
    do_op(0, 19'h7FFFF, 16'h0, 2'b10, 0);

    for (int k = 0; k < 80; k++)
      do_op(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'(($urandom % 3) + 1), 0);

    chk(v_ready == 0, "R8 ready low while selected", v_ready, 0);
    chk(v_addr == 0, "R2 address phase pins", v_addr, 0);
    chk(v_hold == 0, "R3 address and write-data hold", v_hold, 0);
    chk(v_turn == 0, "R4 bus turnaround", v_turn, 0);
    chk(v_rec == 0, "R9 recovery before driving", v_rec, 0);
    chk(v_wdata == 0, "R6 write data during enable", v_wdata, 0);
    chk(v_strb == 0, "R7 byte strobes", v_strb, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule